// File: doc/BRIEF.md
# Modulo Timer Counter with Coherent Byte Access

This block is a 16-bit up-counter or up/down counter for a small controller. It is reached through an 8-bit register port. Each cycle in which the count strobe is high and the clock-select field is non-zero moves the counter one step.

The counter runs up to a programmable ceiling. In edge mode it then wraps to zero. In center mode it reverses and runs back down to zero. At the top it raises an overflow flag, and it raises an interrupt when that is enabled.

Software reads the counter one byte at a time through a holding buffer, so the two halves always belong to the same instant. Software writes the ceiling one byte at a time. While only one half of the ceiling has been written, the overflow flag cannot be set.

The register port is a plain control interface: one access per cycle with no wait states, so there is no back-pressure. The read data is combinational from the address. Side effects of a read take place at the clock edge of the read cycle.

Top module: `tmr_modulo_timer`

## Requirements
- R1: Register addresses are: 0 for status/control, 1 for counter high byte, 2 for counter low byte, 3 for ceiling high byte and 4 for ceiling low byte. The status/control bits are: 7 overflow flag, 6 interrupt enable, 5 center mode, 4:3 clock select; bits 2:0 read 0. After reset every register reads 0x00 and `irq` is low.
- R2: A read of either counter byte while the buffer is empty captures the whole counter and returns the live byte. Later reads of the same byte return the captured value. A read of the other byte returns the captured value and empties the buffer. This gives coherent reads in either order.
- R3: A write to either counter address, or any write to status/control, empties the holding buffer.
- R4: In edge mode the counter steps 0,1,…,top. A step taken at a value at or above top loads 0 and sets the flag. top is the ceiling value, or 0xFFFF when the ceiling is zero.
- R5: In center mode the counter steps up to top, then down to 0, then up again. The flag is set on the step taken at top.
- R6: After one ceiling byte is written, the flag is not set until the other ceiling byte has also been written. The counter still wraps during that time.
- R7: A ceiling of 0x0000 lets the counter run through all 65536 values. It wraps from 0xFFFF to 0x0000 and sets the flag.
- R8: The flag clears only when software reads status/control while the flag is 1 and then writes status/control with bit 7 at 0. A write with no such preceding read leaves the flag set. `irq` is the flag ANDed with the interrupt enable.
- R9: The counter moves only in a cycle with `cnt_tick` high and clock select non-zero. Otherwise it holds its value.
- R10: A write of any value to a counter byte loads 0x0000 and sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cnt_tick | input | 1 | Single-cycle count enable strobe |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong step rule or a wrong direction bit appears at the counter byte reads on the very next strobe. Within one sweep period over small ceilings it becomes a wrong value compared with the arithmetic sequence.

A buffer that is captured or emptied at the wrong moment shows up in the second byte of a split read. That byte carries the high or low half of a later count. A half-write guard that fails to suppress, or a flag that clears too easily, shows on `irq` and bit 7 of status within one wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_MOD_HI = 3'd3,
    A_MOD_LO = 3'd4
  } reg_addr_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    HALF_NONE    = 2'd0,
    HALF_WAIT_LO = 2'd1,
    HALF_WAIT_HI = 2'd2
  } half_e;

  // status/control field layout (bits of the register byte, MSB side)
  localparam int unsigned CTL_FIELDS = 5;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic             center,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top,
  output dir_e             dir,
  output logic             top_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_n;
  dir_e             dir_n;

  assign top = (mod_val == '0) ? '1 : mod_val;

  always_comb begin
    cnt_n   = cnt;
    dir_n   = dir;
    top_evt = 1'b0;
    if (clr) begin
      cnt_n = '0;
      dir_n = DIR_UP;
    end else if (adv) begin
      if (!center) begin
        dir_n = DIR_UP;
        if (cnt >= top) begin
          cnt_n   = '0;
          top_evt = 1'b1;
        end else begin
          cnt_n = cnt + ONE;
        end
      end else if (dir == DIR_UP) begin
        if (cnt >= top) begin
          cnt_n   = cnt - ONE;
          dir_n   = DIR_DOWN;
          top_evt = 1'b1;
        end else begin
          cnt_n = cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          cnt_n = ONE;
          dir_n = DIR_UP;
        end else begin
          cnt_n = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else begin
      cnt <= cnt_n;
      dir <= dir_n;
    end
  end
endmodule

// File: rtl/tmr_read_latch.sv
module tmr_read_latch #(
  parameter int unsigned BUS_W = 8,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             release_i,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] view,
  output logic             held,
  output logic [CNT_W-1:0] hold_buf
);
  logic first_hi;
  logic other_rd;

  assign other_rd = (rd_hi && !first_hi) || (rd_lo && first_hi);
  assign view     = held ? hold_buf : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      first_hi <= 1'b0;
      hold_buf <= '0;
    end else if (release_i) begin
      held <= 1'b0;
    end else if (rd_hi || rd_lo) begin
      if (!held) begin
        held     <= 1'b1;
        hold_buf <= cnt;
        first_hi <= rd_hi;
      end else if (other_rd) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_modulo_reg.sv
module tmr_modulo_reg
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] mod_val,
  output logic             pending
);
  half_e half_q;

  assign pending = (half_q != HALF_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_val <= '0;
      half_q  <= HALF_NONE;
    end else if (wr_hi) begin
      mod_val[CNT_W-1:BUS_W] <= wdata;
      half_q <= (half_q == HALF_WAIT_HI) ? HALF_NONE : HALF_WAIT_LO;
    end else if (wr_lo) begin
      mod_val[BUS_W-1:0] <= wdata;
      half_q <= (half_q == HALF_WAIT_LO) ? HALF_NONE : HALF_WAIT_HI;
    end
  end
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [CTL_FIELDS-1:0] wbits,
  input  logic                  set_evt,
  output logic [BUS_W-1:0]      ctl_byte,
  output logic                  flag,
  output logic                  ie,
  output logic                  center,
  output logic [1:0]            clksel,
  output logic                  irq
);
  logic armed;

  assign ctl_byte = {flag, ie, center, clksel, {(BUS_W-CTL_FIELDS){1'b0}}};
  assign irq      = flag & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie     <= 1'b0;
      center <= 1'b0;
      clksel <= 2'b00;
    end else if (wr) begin
      ie     <= wbits[3];
      center <= wbits[2];
      clksel <= wbits[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (wr)             armed <= 1'b0;
      else if (rd && flag) armed <= 1'b1;

      if (set_evt)                          flag <= 1'b1;
      else if (wr && armed && !wbits[4])    flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_modulo_timer.sv
module tmr_modulo_timer
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             cnt_tick,
  output logic             irq
);
  localparam int unsigned CNT_W = 2 * BUS_W;

  logic             sel_ctl, sel_chi, sel_clo, sel_mhi, sel_mlo;
  logic             cnt_clr, cnt_adv, latch_rel, set_evt;
  logic [CNT_W-1:0] cnt_q, top_q, mod_q, cnt_view, hold_buf;
  logic             top_evt, mod_pend, latch_held;
  logic             flag, ie, center;
  logic [1:0]       clksel;
  logic [BUS_W-1:0] ctl_byte;
  dir_e             dir_q;

  assign sel_ctl = (bus_addr == A_CTRL);
  assign sel_chi = (bus_addr == A_CNT_HI);
  assign sel_clo = (bus_addr == A_CNT_LO);
  assign sel_mhi = (bus_addr == A_MOD_HI);
  assign sel_mlo = (bus_addr == A_MOD_LO);

  assign cnt_clr   = bus_wr && (sel_chi || sel_clo);
  assign latch_rel = cnt_clr || (bus_wr && sel_ctl);
  assign cnt_adv   = cnt_tick && (clksel != 2'b00);
  assign set_evt   = top_evt && !mod_pend;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (cnt_adv),
    .clr     (cnt_clr),
    .center  (center),
    .mod_val (mod_q),
    .cnt     (cnt_q),
    .top     (top_q),
    .dir     (dir_q),
    .top_evt (top_evt)
  );

  tmr_read_latch #(.BUS_W(BUS_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hi     (bus_rd && sel_chi),
    .rd_lo     (bus_rd && sel_clo),
    .release_i (latch_rel),
    .cnt       (cnt_q),
    .view      (cnt_view),
    .held      (latch_held),
    .hold_buf  (hold_buf)
  );

  tmr_modulo_reg #(.BUS_W(BUS_W)) u_mod (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (bus_wr && sel_mhi),
    .wr_lo   (bus_wr && sel_mlo),
    .wdata   (bus_wdata),
    .mod_val (mod_q),
    .pending (mod_pend)
  );

  tmr_ctrl_reg #(.BUS_W(BUS_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr && sel_ctl),
    .rd       (bus_rd && sel_ctl),
    .wbits    (bus_wdata[BUS_W-1 -: CTL_FIELDS]),
    .set_evt  (set_evt),
    .ctl_byte (ctl_byte),
    .flag     (flag),
    .ie       (ie),
    .center   (center),
    .clksel   (clksel),
    .irq      (irq)
  );

  always_comb begin
    unique case (1'b1)
      sel_ctl: bus_rdata = ctl_byte;
      sel_chi: bus_rdata = cnt_view[CNT_W-1:BUS_W];
      sel_clo: bus_rdata = cnt_view[BUS_W-1:0];
      sel_mhi: bus_rdata = mod_q[CNT_W-1:BUS_W];
      sel_mlo: bus_rdata = mod_q[BUS_W-1:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_timer_checker.sv
module tmr_timer_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             adv,
  input logic             clr,
  input logic             center,
  input logic             dir_down,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top,
  input logic             flag,
  input logic             pending,
  input logic             held,
  input logic [CNT_W-1:0] hold_buf
);
  // R4: edge-mode step at or above top lands on zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !center && cnt >= top) |=> (cnt == '0));

  // R5: center-mode step at top turns the direction down
  p_center_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && center && !dir_down && cnt >= top) |=> dir_down);

  // R6: no flag rise while the ceiling is half written
  p_no_flag_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !flag) |=> !flag);

  // R9: no strobe, no move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt));

  // R2: captured value stays put while held
  p_buf_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !bus_wr) |=> $stable(hold_buf));

  // R10: counter write restarts at zero counting up
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !dir_down));
endmodule

bind tmr_modulo_timer tmr_timer_checker #(.CNT_W(2 * BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .adv      (cnt_adv),
  .clr      (cnt_clr),
  .center   (center),
  .dir_down (dir_q == tmr_pkg::DIR_DOWN),
  .cnt      (cnt_q),
  .top      (top_q),
  .flag     (flag),
  .pending  (mod_pend),
  .held     (latch_held),
  .hold_buf (hold_buf)
);

// File: tb/sim_tmr_modulo_timer.sv
`timescale 1ns/100ps
module sim_tmr_modulo_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cnt_tick = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_modulo_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk) bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk) bus_wr = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'd1, h); rd(3'd2, l);
    v = {h, l};
  endtask

  task automatic tick(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic clear_flag(input logic [7:0] ctl);
    logic [7:0] s;
    rd(3'd0, s); wr(3'd0, ctl);
  endtask

  function automatic int exp_cnt(input bit ctr, input int top, input int k);
    int p;
    if (!ctr) return k % (top + 1);
    p = k % (2 * top);
    return (p <= top) ? p : 2 * top - p;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic [7:0]  ctl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b); chk("R1 reset read", b, 0);
    end
    chk("R1 irq", irq, 0);

    // R4 / R5 sweeps over small ceilings
    for (int md = 0; md < 2; md++) begin
      for (int m = 1; m <= 5; m++) begin
        ctl = (md != 0) ? 8'h28 : 8'h08;
        wr(3'd0, ctl); wr(3'd3, 8'h00); wr(3'd4, 8'(m)); wr(3'd1, 8'h00);
        clear_flag(ctl);
        for (int k = 0; k <= 4 * m + 1; k++) begin
          rd16(v);
          chk((md != 0) ? "R5 count" : "R4 count", v, exp_cnt(md != 0, m, k));
          rd(3'd0, b);
          chk((md != 0) ? "R5 flag" : "R4 flag", b[7], (k >= m + 1) ? 1 : 0);
          tick(1);
        end
      end
    end

    // R10 counter write restarts upward
    wr(3'd0, 8'h28); wr(3'd3, 8'h00); wr(3'd4, 8'h03); wr(3'd1, 8'h00);
    tick(4);
    rd16(v); chk("R10 pre", v, 2);
    wr(3'd2, 8'hAB);
    rd16(v); chk("R10 cleared", v, 0);
    tick(1);
    rd16(v); chk("R10 direction up", v, 1);

    // R2 / R3 coherent reads
    wr(3'd0, 8'h08); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd1, 8'h00);
    tick(250);
    rd(3'd2, b); chk("R2 low first live", b, 8'hFA);
    tick(10);
    rd(3'd1, b); chk("R2 high from buffer", b, 8'h00);
    rd(3'd2, b); chk("R2 low live after release", b, 8'h04);
    tick(300);
    rd(3'd2, b); chk("R2 same byte repeat", b, 8'h04);
    rd(3'd1, b); chk("R2 high first order", b, 8'h01);
    rd(3'd1, b); chk("R2 high capture", b, 8'h02);
    tick(5);
    wr(3'd0, 8'h08);
    rd(3'd2, b); chk("R3 status write releases", b, 8'h35);
    wr(3'd1, 8'h00);
    rd(3'd1, b); chk("R3 counter write releases", b, 8'h00);
    rd(3'd2, b); chk("R3 counter write low", b, 8'h00);

    // R9 clock select zero holds
    tick(7);
    wr(3'd0, 8'h00);
    tick(5);
    rd16(v); chk("R9 hold", v, 7);
    wr(3'd0, 8'h08);
    tick(1);
    rd16(v); chk("R9 advance", v, 8);

    // R6 half-written ceiling suppresses the flag
    wr(3'd0, 8'h48); wr(3'd3, 8'h00); wr(3'd4, 8'h02); wr(3'd1, 8'h00);
    clear_flag(8'h48);
    wr(3'd3, 8'h00);
    tick(3);
    rd16(v); chk("R6 still wraps", v, 0);
    rd(3'd0, b); chk("R6 flag suppressed", b, 8'h48);
    chk("R6 irq suppressed", irq, 0);
    wr(3'd4, 8'h02);
    tick(3);
    chk("R6 flag after full write", irq, 1);

    // R8 clear sequence and irq gating
    wr(3'd0, 8'h48);
    chk("R8 write without read keeps flag", irq, 1);
    wr(3'd0, 8'h08);
    chk("R8 irq gated by enable", irq, 0);
    rd(3'd0, b); chk("R8 flag still set", b, 8'h88);
    wr(3'd0, 8'h48);
    rd(3'd0, b); chk("R8 flag cleared", b, 8'h48);
    chk("R8 irq low", irq, 0);

    // R7 free run over full range
    wr(3'd0, 8'h08); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd1, 8'h00);
    clear_flag(8'h08);
    tick(65535);
    rd16(v); chk("R7 top value", v, 16'hFFFF);
    rd(3'd0, b); chk("R7 no flag yet", b, 8'h08);
    tick(1);
    rd16(v); chk("R7 wrapped", v, 0);
    rd(3'd0, b); chk("R7 flag", b, 8'h88);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule